// File: doc/BRIEF.md
# Configurable 4:2:2 Video Pixel Port Formatter

The formatter takes a 4:2:2 standard-definition stream as pixel pairs of 10-bit samples (two lumas, one blue-difference and one red-difference chroma). It drives them onto a 20-bit output pin group, with a data value and an output enable for every pin. A 4-bit format code picks the layout. Two layouts are interleaved narrow streams, 10-bit or 8-bit, that carry one word per pixel clock. Two are wide streams, 20-bit or 16-bit, with luma and chroma on separate lanes, where each word is held for two pixel clocks.

The block runs from the full-rate pixel clock and handles one pixel pair every four clocks. It pulses `pair_take_o` in the cycle whose closing edge captures the sample inputs and the whole configuration. Because of this, a format, swap or clock change always begins on a pixel-pair boundary. A pixel-rate output clock is also produced. It is either the full-rate clock or a registered half-rate clock aligned with the data, and its polarity can be inverted.

Top module: `pix_port_fmt`

## Requirements
- R1: While `rst_n` is low, `pix_d` and `pix_oe` are all zero. After reset the captured format is 0011 (8-bit interleaved), whatever `fmt_sel` holds, until the first pair capture. A pin whose enable is low always shows 0 on `pix_d`.
- R2: A pair is captured at the clock edge that ends a cycle with `pair_take_o` high. Interleaved words appear one per clock after the next four edges, in the order Cb, Y0, Cr, Y1.
- R3: With the captured `swap_cbcr` = 1, the two chroma samples exchange places, giving Cr, Y0, Cb, Y1 for interleaved formats and Cr before Cb for wide formats.
- R4: Format 0000 drives each 10-bit interleaved word on `pix_d[19:10]`, enables exactly pins 19..10 (`pix_oe` = 20'hFFC00) and disables pins 9..0.
- R5: Format 0011 drives bits [9:2] of each interleaved word on `pix_d[19:12]`, truncating without rounding, and enables exactly pins 19..12 (20'hFF000).
- R6: Format 0001 drives Y on `pix_d[19:10]` and chroma on `pix_d[9:0]` with all pins enabled. Y0 with the first chroma is shown for two clocks, then Y1 with the second chroma for two clocks.
- R7: Format 0010 uses the same half-rate timing as R6. It drives Y[9:2] on `pix_d[19:12]` and chroma[9:2] on `pix_d[9:2]`, with `pix_oe` = 20'hFF3FC.
- R8: Every other format code (0100 through 1111) disables all 20 pins.
- R9: A change of `fmt_sel` in the middle of a pair leaves the rest of that pair in the captured format.
- R10: With captured clock select 101, `pix_clk_o` is a registered half-rate clock that is high during the clocks carrying words 1 and 3 (luma) and low during words 0 and 2 (chroma). Any other select value gives the full-rate input clock.
- R11: With the captured `clk_pol` = 1, `pix_clk_o` is inverted, for both the full-rate and the half-rate clock.
- R12: `pair_take_o` is high in exactly one cycle out of every four, in the third clock after the word-0 edge of the current pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 4 | Output format code |
| swap_cbcr | input | 1 | Exchange Cb and Cr positions |
| clk_sel | input | 3 | Output clock select (101 = half rate) |
| clk_pol | input | 1 | Invert output clock |
| y0_i | input | 10 | First luma of the pair |
| y1_i | input | 10 | Second luma of the pair |
| cb_i | input | 10 | Blue-difference chroma of the pair |
| cr_i | input | 10 | Red-difference chroma of the pair |
| pair_take_o | output | 1 | Inputs and configuration are captured at the next edge |
| pix_d | output | 20 | Output pin data |
| pix_oe | output | 20 | Per-pin output enable |
| pix_clk_o | output | 1 | Pixel-rate output clock |

## Verification
The bench walks all sixteen format codes with both swap settings and several sample patterns. It checks every word of every pair for data, enables and clock level. A wrong chroma order or a missed swap shows up as Cb and Cr in the wrong word slots. Dropping the wide-mode hold would put Y1 in the second clock of a pair, and rounding or mis-slicing the 8-bit formats would change the low bits on the pins. The bench also changes the format in the middle of a pair: a design that applies the change at once would re-map the pins too early. It also checks the reserved codes 0100 and 0101 and both clock polarities, where a decoder missing a code would leave pins enabled or put the half-rate clock in the wrong phase relative to luma.

// File: rtl/pix_port_fmt.sv
module pix_port_fmt #(
  parameter int SW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      fmt_sel,
  input  logic            swap_cbcr,
  input  logic [2:0]      clk_sel,
  input  logic            clk_pol,
  input  logic [SW-1:0]   y0_i,
  input  logic [SW-1:0]   y1_i,
  input  logic [SW-1:0]   cb_i,
  input  logic [SW-1:0]   cr_i,
  output logic            pair_take_o,
  output logic [2*SW-1:0] pix_d,
  output logic [2*SW-1:0] pix_oe,
  output logic            pix_clk_o
);
  localparam int BW = 2 * SW;
  localparam int NB = SW - 2;
  localparam logic [3:0] F_I10 = 4'b0000;
  localparam logic [3:0] F_W20 = 4'b0001;
  localparam logic [3:0] F_W16 = 4'b0010;
  localparam logic [3:0] F_I8  = 4'b0011;
  localparam logic [2:0] CK_HALF = 3'b101;

  logic [1:0]    ph;
  logic [3:0]    cm;
  logic          cswp, cpol, hck;
  logic [2:0]    csel;
  logic [SW-1:0] sy0, sy1, scb, scr;
  logic [SW-1:0] c0, c1, w, wy, wc;
  logic [BW-1:0] nd, noe;

  assign pair_take_o = (ph == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      cm   <= F_I8;
      cswp <= 1'b0;
      csel <= 3'b000;
      cpol <= 1'b0;
      sy0  <= '0;
      sy1  <= '0;
      scb  <= '0;
      scr  <= '0;
    end else begin
      ph <= ph + 2'd1;
      if (pair_take_o) begin
        cm   <= fmt_sel;
        cswp <= swap_cbcr;
        csel <= clk_sel;
        cpol <= clk_pol;
        sy0  <= y0_i;
        sy1  <= y1_i;
        scb  <= cb_i;
        scr  <= cr_i;
      end
    end
  end

  assign c0 = cswp ? scr : scb;
  assign c1 = cswp ? scb : scr;
  assign wy = ph[1] ? sy1 : sy0;
  assign wc = ph[1] ? c1 : c0;

  always_comb begin
    case (ph)
      2'd0:    w = c0;
      2'd1:    w = sy0;
      2'd2:    w = c1;
      default: w = sy1;
    endcase
  end

  always_comb begin
    nd  = '0;
    noe = '0;
    case (cm)
      F_I10: begin
        nd[BW-1:SW]  = w;
        noe[BW-1:SW] = '1;
      end
      F_I8: begin
        nd[BW-1:BW-NB]  = w[SW-1:2];
        noe[BW-1:BW-NB] = '1;
      end
      F_W20: begin
        nd  = {wy, wc};
        noe = '1;
      end
      F_W16: begin
        nd[BW-1:BW-NB]  = wy[SW-1:2];
        nd[SW-1:2]      = wc[SW-1:2];
        noe[BW-1:BW-NB] = '1;
        noe[SW-1:2]     = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_d  <= '0;
      pix_oe <= '0;
      hck    <= 1'b1;
    end else begin
      pix_d  <= nd;
      pix_oe <= noe;
      hck    <= ph[0];
    end
  end

  assign pix_clk_o = ((csel == CK_HALF) ? hck : clk) ^ cpol;

  // R12
  take_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_take_o |=> !pair_take_o);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_take_o |=> ($stable(cm) && $stable(cswp) && $stable(csel)));

  // R1
  idle_pin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_d & ~pix_oe) == '0);

  // R4
  wide10_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_take_o && cm == F_I10) |=> (pix_oe == {{SW{1'b1}}, {SW{1'b0}}}));

  // R8
  reserved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_take_o && cm > F_I8) |=> (pix_oe == '0));

  // R10
  half_clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_take_o && csel == CK_HALF) |=> (pix_clk_o != $past(pix_clk_o)));
endmodule

// File: tb/test_pix_port_fmt.sv
module test_pix_port_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt_sel = 4'b0000;
  logic        swap_cbcr = 1'b0;
  logic [2:0]  clk_sel = 3'b000;
  logic        clk_pol = 1'b0;
  logic [9:0]  y0_i = '0, y1_i = '0, cb_i = '0, cr_i = '0;
  logic        pair_take_o;
  logic [19:0] pix_d, pix_oe;
  logic        pix_clk_o;

  int n_cmp = 0;
  int n_bad = 0;

  pix_port_fmt i_pix_port_fmt (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .swap_cbcr(swap_cbcr),
    .clk_sel(clk_sel), .clk_pol(clk_pol), .y0_i(y0_i), .y1_i(y1_i),
    .cb_i(cb_i), .cr_i(cr_i), .pair_take_o(pair_take_o), .pix_d(pix_d),
    .pix_oe(pix_oe), .pix_clk_o(pix_clk_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string mtag(input logic [3:0] m);
    case (m)
      4'b0000: return "R4";
      4'b0011: return "R5";
      4'b0001: return "R6";
      4'b0010: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [9:0] wsel(input int k, input logic sw,
      input logic [9:0] y0, input logic [9:0] y1, input logic [9:0] cb, input logic [9:0] cr);
    case (k)
      0: return sw ? cr : cb;
      1: return y0;
      2: return sw ? cb : cr;
      default: return y1;
    endcase
  endfunction

  function automatic logic [19:0] exp_oe(input logic [3:0] m);
    case (m)
      4'b0000: return 20'hFFC00;
      4'b0011: return 20'hFF000;
      4'b0001: return 20'hFFFFF;
      4'b0010: return 20'hFF3FC;
      default: return 20'h00000;
    endcase
  endfunction

  function automatic logic [19:0] exp_d(input logic [3:0] m, input int k, input logic sw,
      input logic [9:0] y0, input logic [9:0] y1, input logic [9:0] cb, input logic [9:0] cr);
    logic [9:0] w, y, c;
    w = wsel(k, sw, y0, y1, cb, cr);
    y = (k < 2) ? y0 : y1;
    c = (k < 2) ? wsel(0, sw, y0, y1, cb, cr) : wsel(2, sw, y0, y1, cb, cr);
    case (m)
      4'b0000: return {w, 10'd0};
      4'b0011: return {w[9:2], 12'd0};
      4'b0001: return {y, c};
      4'b0010: return {y[9:2], 2'd0, c[9:2], 2'd0};
      default: return 20'd0;
    endcase
  endfunction

  task automatic run_pair(input logic [3:0] m, input logic sw, input logic [2:0] cs,
      input logic pl, input logic [9:0] y0, input logic [9:0] y1, input logic [9:0] cb,
      input logic [9:0] cr, input bit mid, input logic [3:0] mid_m);
    logic ck;
    fmt_sel = m; swap_cbcr = sw; clk_sel = cs; clk_pol = pl;
    y0_i = y0; y1_i = y1; cb_i = cb; cr_i = cr;
    while (pair_take_o !== 1'b1) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      chk({mid && k > 0 ? "R9 " : (k == 1 || k == 3 ? "R2 " : "R3 "), mtag(m), " d"},
          pix_d, exp_d(m, k, sw, y0, y1, cb, cr));
      chk({mid && k > 0 ? "R9 " : "", mtag(m), " oe"}, pix_oe, exp_oe(m));
      ck = ((cs == 3'b101) ? k[0] : 1'b1) ^ pl;
      chk(pl ? "R11 clk" : "R10 clk", {19'd0, pix_clk_o}, {19'd0, ck});
      if (k < 3) chk("R12 take", {19'd0, pair_take_o}, {19'd0, (k == 2)});
      if (mid && k == 0) fmt_sel = mid_m;
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset oe", pix_oe, 20'd0);
    chk("R1 reset d", pix_d, 20'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 default fmt oe", pix_oe, 20'hFF000);
    chk("R1 default fmt d", pix_d, 20'd0);
    for (int m = 0; m < 16; m++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++)
          run_pair(4'(m), s[0], 3'b000, 1'b0,
                   10'(m * 37 + p * 301 + 5), 10'(m * 53 + p * 199 + 771),
                   10'(m * 29 + s * 87 + 3 + p * 512), 10'(m * 71 + 1022 - p * 6),
                   1'b0, 4'b0000);
    run_pair(4'b0001, 1'b0, 3'b101, 1'b0, 10'h3FF, 10'h001, 10'h2AA, 10'h155, 1'b0, 4'd0);
    run_pair(4'b0001, 1'b1, 3'b101, 1'b1, 10'h123, 10'h3C5, 10'h0F0, 10'h30F, 1'b0, 4'd0);
    run_pair(4'b0010, 1'b0, 3'b101, 1'b1, 10'h1FF, 10'h203, 10'h3FE, 10'h001, 1'b0, 4'd0);
    run_pair(4'b0000, 1'b0, 3'b000, 1'b1, 10'h2B7, 10'h16C, 10'h3A1, 10'h05E, 1'b0, 4'd0);
    run_pair(4'b0011, 1'b1, 3'b101, 1'b0, 10'h2B7, 10'h16C, 10'h3A1, 10'h05E, 1'b0, 4'd0);
    run_pair(4'b0011, 1'b0, 3'b010, 1'b0, 10'h003, 10'h3FC, 10'h101, 10'h2FE, 1'b0, 4'd0);
    run_pair(4'b0000, 1'b0, 3'b000, 1'b0, 10'h111, 10'h222, 10'h333, 10'h044, 1'b1, 4'b0001);
    run_pair(4'b0010, 1'b1, 3'b000, 1'b0, 10'h3AB, 10'h0CD, 10'h1EF, 10'h201, 1'b1, 4'b1111);
    run_pair(4'b0001, 1'b0, 3'b000, 1'b0, 10'h155, 10'h2AA, 10'h0FF, 10'h300, 1'b1, 4'b0011);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule